// File: doc/BRIEF.md
# Dual-Rate Serial Baud Generator

This block turns the bus clock into the rate enables needed by the transmit and receive halves of an asynchronous serial port. One shared prescaler divides the bus clock by 1, 3, 4 or 13. Two independent divider chains, one for transmit and one for receive, then divide the prescaled rate by a power of two. A separate 8-bit fine divisor for each chain can stand in for that power of two. Each chain produces a 16x oversampling tick and a bit-rate enable. All outputs are single-cycle pulses.

Software writes one 8-bit rate word through a write strobe. The two fine divisors arrive as static register values. When the fine divisor of a path is zero, that path uses its coarse power-of-two code. When it is nonzero, the fine value is the dividing factor. A rate-word write restarts every counter. A change of one fine divisor restarts only its own path. In both cases the first period after the change is never a blend of the old and new settings.

Top module: `baud_gen_dual`

## Requirements
- R1: After reset the rate word is all zeros. With both fine divisors at zero, both oversampling ticks are high on every bus clock.
- R2: Rate word layout: bits 7:6 select the prescaler, bits 5:3 select the transmit code, and bits 2:0 select the receive code.
- R3: Prescaler select 00, 01, 10, 11 gives a division by 1, 3, 4, 13.
- R4: A transmit code n (0 to 7) gives a transmit factor of 2^n, so codes 000 to 111 give 1 to 128.
- R5: The receive code uses the same 2^n mapping and is independent of the transmit code.
- R6: A nonzero transmit fine divisor f sets the transmit factor to f. Returning it to zero restores the coarse transmit code.
- R7: A nonzero receive fine divisor f sets the receive factor to f. Returning it to zero restores the coarse receive code. The transmit path is unaffected.
- R8: The oversampling tick of a path repeats every P*F bus clocks, where P is the prescaler ratio and F is the path factor.
- R9: A bit enable is high on every 16th oversampling tick of its path, always in the same cycle as that tick.
- R10: A rate-word write clears all counters at its clock edge. Each path's first tick is then high in the cycle ending P*F edges after the write edge. A change of one fine divisor clears only that path's counters.
- R11: Every output is high for one cycle at a time. A bit enable is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rateWe | input | 1 | Write strobe for the rate word |
| rateWdata | input | 8 | Rate word: prescaler, transmit code, receive code |
| txFine | input | 8 | Transmit fine divisor, 0 selects the coarse code |
| rxFine | input | 8 | Receive fine divisor, 0 selects the coarse code |
| txOvsTick | output | 1 | Transmit 16x oversampling tick |
| rxOvsTick | output | 1 | Receive 16x oversampling tick |
| txBitEn | output | 1 | Transmit bit-rate enable |
| rxBitEn | output | 1 | Receive bit-rate enable |

## Verification
A wrong prescaler or divider count shows at the ports as a tick that comes early or late. This appears within one P*F period of the fault, which can be up to 3315 bus clocks for the largest factors. A wrong bit counter only shows on the bit enable, so it can take up to sixteen oversampling periods to appear. A reload that misses a counter shows as a first tick after a write or fine change that arrives away from its expected edge. Comparing every cycle against a behavioural model reports any such fault in the first cycle where an output differs.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int RateWordW = 8;
  localparam int PreSelW   = 2;
  localparam int CodeW     = 3;
  localparam int PreCntW   = 4;
  localparam int NumPaths  = 2;
  localparam int TxIdx     = 0;
  localparam int RxIdx     = 1;

  typedef struct packed {
    logic                preReload;
    logic [NumPaths-1:0] pathReload;
  } strobes_t;

  // terminal count of the shared prescaler: ratio minus one
  function automatic logic [PreCntW-1:0] preLimitOf(input logic [PreSelW-1:0] sel);
    case (sel)
      2'd0:    preLimitOf = PreCntW'(0);
      2'd1:    preLimitOf = PreCntW'(2);
      2'd2:    preLimitOf = PreCntW'(3);
      default: preLimitOf = PreCntW'(12);
    endcase
  endfunction

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int FINE_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rateWe,
  input  logic [RateWordW-1:0]             rateWdata,
  input  logic [NumPaths-1:0][FINE_W-1:0]  fineIn,
  output strobes_t                         strb,
  output logic [PreCntW-1:0]               preLim,
  output logic [NumPaths-1:0][FINE_W-1:0]  pathLim
);

  logic [PreSelW-1:0]                preSel;
  logic [NumPaths-1:0][CodeW-1:0]    codeSel;
  logic [NumPaths-1:0][FINE_W-1:0]   fineQ;
  logic [NumPaths-1:0]               fineChg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preSel  <= '0;
      codeSel <= '0;
    end else if (rateWe) begin
      preSel           <= rateWdata[7:6];
      codeSel[TxIdx]   <= rateWdata[5:3];
      codeSel[RxIdx]   <= rateWdata[2:0];
    end
  end

  assign preLim         = preLimitOf(preSel);
  assign strb.preReload = rateWe;

  for (genvar p = 0; p < NumPaths; p++) begin : g_path
    assign fineChg[p] = (fineIn[p] != fineQ[p]);

    always_ff @(posedge clk) begin
      if (!rst_n)          fineQ[p] <= '0;
      else if (fineChg[p]) fineQ[p] <= fineIn[p];
    end

    assign strb.pathReload[p] = rateWe | fineChg[p];
    assign pathLim[p] = (fineQ[p] != '0) ? (fineQ[p] - FINE_W'(1))
                                         : ((FINE_W'(1) << codeSel[p]) - FINE_W'(1));
  end

endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int FINE_W    = 8,
  parameter int OVS_RATIO = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  strobes_t                         strb,
  input  logic [PreCntW-1:0]               preLim,
  input  logic [NumPaths-1:0][FINE_W-1:0]  pathLim,
  output logic [NumPaths-1:0]              ovsTick,
  output logic [NumPaths-1:0]              bitEn
);

  localparam int OvsW = (OVS_RATIO > 1) ? $clog2(OVS_RATIO) : 1;

  logic [PreCntW-1:0] preCnt;
  logic               preTick;

  assign preTick = (preCnt == preLim);

  always_ff @(posedge clk) begin
    if (!rst_n)              preCnt <= '0;
    else if (strb.preReload) preCnt <= '0;
    else if (preTick)        preCnt <= '0;
    else                     preCnt <= preCnt + PreCntW'(1);
  end

  for (genvar p = 0; p < NumPaths; p++) begin : g_chain
    logic [FINE_W-1:0] divCnt;
    logic [OvsW-1:0]   ovsCnt;

    assign ovsTick[p] = preTick && (divCnt == pathLim[p]);
    assign bitEn[p]   = ovsTick[p] && (ovsCnt == OvsW'(OVS_RATIO - 1));

    always_ff @(posedge clk) begin
      if (!rst_n || strb.pathReload[p]) begin
        divCnt <= '0;
        ovsCnt <= '0;
      end else begin
        if (preTick)
          divCnt <= ovsTick[p] ? '0 : divCnt + FINE_W'(1);
        if (ovsTick[p])
          ovsCnt <= bitEn[p] ? '0 : ovsCnt + OvsW'(1);
      end
    end
  end

endmodule

// File: rtl/baud_gen_dual.sv
module baud_gen_dual
  import baud_pkg::*;
#(
  parameter int OVS_RATIO = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rateWe,
  input  logic [7:0] rateWdata,
  input  logic [7:0] txFine,
  input  logic [7:0] rxFine,
  output logic       txOvsTick,
  output logic       rxOvsTick,
  output logic       txBitEn,
  output logic       rxBitEn
);

  localparam int FineW = 8;

  strobes_t                       strb;
  logic [PreCntW-1:0]             preLim;
  logic [NumPaths-1:0][FineW-1:0] pathLim;
  logic [NumPaths-1:0][FineW-1:0] fineIn;
  logic [NumPaths-1:0]            ovsTick;
  logic [NumPaths-1:0]            bitEn;

  assign fineIn[TxIdx] = txFine;
  assign fineIn[RxIdx] = rxFine;

  baud_ctrl #(.FINE_W(FineW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rateWe    (rateWe),
    .rateWdata (rateWdata),
    .fineIn    (fineIn),
    .strb      (strb),
    .preLim    (preLim),
    .pathLim   (pathLim)
  );

  baud_datapath #(.FINE_W(FineW), .OVS_RATIO(OVS_RATIO)) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .preLim  (preLim),
    .pathLim (pathLim),
    .ovsTick (ovsTick),
    .bitEn   (bitEn)
  );

  assign txOvsTick = ovsTick[TxIdx];
  assign rxOvsTick = ovsTick[RxIdx];
  assign txBitEn   = bitEn[TxIdx];
  assign rxBitEn   = bitEn[RxIdx];

endmodule

// File: rtl/baud_chk.sv
module baud_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rateWe,
  input logic [7:0] rateWdata,
  input logic [7:0] txFine,
  input logic [7:0] rxFine,
  input logic       txOvsTick,
  input logic       rxOvsTick,
  input logic       txBitEn,
  input logic       rxBitEn
);

  // R9
  tx_bit_in_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txBitEn |-> txOvsTick);

  // R9
  rx_bit_in_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxBitEn |-> rxOvsTick);

  // R11
  tx_bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txBitEn |=> !txBitEn);

  // R11
  rx_bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxBitEn |=> !rxBitEn);

  // R10
  unit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rateWe && rateWdata[7:3] == 5'd0 && txFine == 8'd0) |=> txOvsTick);

  // R3
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rateWe && rateWdata[7:6] != 2'd0) |=> (!txOvsTick && !rxOvsTick));

endmodule

bind baud_gen_dual baud_chk i_baud_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rateWe    (rateWe),
  .rateWdata (rateWdata),
  .txFine    (txFine),
  .rxFine    (rxFine),
  .txOvsTick (txOvsTick),
  .rxOvsTick (rxOvsTick),
  .txBitEn   (txBitEn),
  .rxBitEn   (rxBitEn)
);

// File: tb/test_baud_gen_dual.sv
`timescale 1ns/1ps
module test_baud_gen_dual;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rateWe = 1'b0;
  logic [7:0] rateWdata = 8'd0;
  logic [7:0] txFine = 8'd0;
  logic [7:0] rxFine = 8'd0;
  logic       txOvsTick, rxOvsTick, txBitEn, rxBitEn;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string reqTag = "R1";

  always #2.5 clk = ~clk;

  baud_gen_dual i_baud_gen_dual (
    .clk(clk), .rst_n(rst_n), .rateWe(rateWe), .rateWdata(rateWdata),
    .txFine(txFine), .rxFine(rxFine), .txOvsTick(txOvsTick),
    .rxOvsTick(rxOvsTick), .txBitEn(txBitEn), .rxBitEn(rxBitEn)
  );

  // ---------------- behavioural reference model ----------------
  int mPre = 0;
  int mSel[2] = '{0, 0};
  int mFine[2] = '{0, 0};
  int mPreCnt = 0;
  int mDiv[2] = '{0, 0};
  int mBit[2] = '{0, 0};

  function automatic int preRatio(input int s);
    case (s)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  function automatic int factorOf(input int p);
    return (mFine[p] != 0) ? mFine[p] : (1 << mSel[p]);
  endfunction

  function automatic bit expTick(input int p);
    return (mPreCnt == preRatio(mPre) - 1) && (mDiv[p] == factorOf(p) - 1);
  endfunction

  function automatic bit expBit(input int p);
    return expTick(p) && (mBit[p] == 15);
  endfunction

  always @(posedge clk) begin
    bit pt;
    bit tk[2];
    int fin;
    bit chg;
    if (!rst_n) begin
      mPre = 0; mSel = '{0, 0}; mFine = '{0, 0};
      mPreCnt = 0; mDiv = '{0, 0}; mBit = '{0, 0};
    end else begin
      pt = (mPreCnt == preRatio(mPre) - 1);
      for (int p = 0; p < 2; p++) tk[p] = expTick(p);
      if (rateWe) begin
        mPre = int'(rateWdata[7:6]);
        mSel[0] = int'(rateWdata[5:3]);
        mSel[1] = int'(rateWdata[2:0]);
        mPreCnt = 0;
      end else begin
        mPreCnt = pt ? 0 : mPreCnt + 1;
      end
      for (int p = 0; p < 2; p++) begin
        fin = (p == 1) ? int'(rxFine) : int'(txFine);
        chg = (fin != mFine[p]);
        if (chg) mFine[p] = fin;
        if (rateWe || chg) begin
          mDiv[p] = 0;
          mBit[p] = 0;
        end else begin
          if (pt) mDiv[p] = tk[p] ? 0 : mDiv[p] + 1;
          if (tk[p]) mBit[p] = (mBit[p] == 15) ? 0 : mBit[p] + 1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [3:0] act, exp;
    act = {txOvsTick, rxOvsTick, txBitEn, rxBitEn};
    exp = {expTick(0), expTick(1), expBit(0), expBit(1)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d outputs {txT,rxT,txB,rxB} actual %b expected %b",
               reqTag, cyc, act, exp);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d actual running expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // write the rate word, then report first-tick latency and next interval
  task automatic writeAndMeasure(input logic [7:0] v, input int expTx, input int expRx,
                                 input string tag);
    int n;
    int tx1, tx2, rx1, rx2;
    rateWe = 1'b1; rateWdata = v;
    @(negedge clk);
    rateWe = 1'b0;
    n = 1; tx1 = 0; tx2 = 0; rx1 = 0; rx2 = 0;
    while ((tx2 == 0 || rx2 == 0) && n < 8000) begin
      if (txOvsTick) begin
        if (tx1 == 0) tx1 = n; else if (tx2 == 0) tx2 = n;
      end
      if (rxOvsTick) begin
        if (rx1 == 0) rx1 = n; else if (rx2 == 0) rx2 = n;
      end
      @(negedge clk);
      n++;
    end
    checkVal({"R10 tx first tick ", tag}, tx1, expTx);
    checkVal({"R10 rx first tick ", tag}, rx1, expRx);
    checkVal({"R8 tx period ", tag}, tx2 - tx1, expTx);
    checkVal({"R8 rx period ", tag}, rx2 - rx1, expRx);
  endtask

  // interval between two consecutive pulses of a selected output
  // sel: 0 txOvsTick, 1 rxOvsTick, 2 txBitEn, 3 rxBitEn
  task automatic measureGap(input int sel, output int gap);
    int n, first;
    logic s;
    n = 0; first = -1; gap = -1;
    while (gap < 0 && n < 20000) begin
      s = (sel == 0) ? txOvsTick : (sel == 1) ? rxOvsTick :
          (sel == 2) ? txBitEn : rxBitEn;
      if (s) begin
        if (first < 0) first = n; else gap = n - first;
      end
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int g;
    int pr;
    reqTag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    checkVal("R1 tx tick right after reset", int'(txOvsTick), 1);
    checkVal("R1 rx tick right after reset", int'(rxOvsTick), 1);
    @(negedge clk);
    checkVal("R1 tx tick every cycle", int'(txOvsTick), 1);

    reqTag = "R9";
    measureGap(2, g);
    checkVal("R9 tx bit enable every 16 ticks at unit factors", g, 16);
    measureGap(3, g);
    checkVal("R9 rx bit enable every 16 ticks at unit factors", g, 16);

    // R2 R3 R4 R5: every prescaler and every code, tx and rx codes differ
    reqTag = "R2 R3 R4 R5";
    for (int ps = 0; ps < 4; ps++) begin
      pr = preRatio(ps);
      for (int c = 0; c < 8; c++) begin
        string t;
        t = $sformatf("R3 pre %0d R4 tx code %0d R5 rx code %0d", ps, c, 7 - c);
        writeAndMeasure({2'(ps), 3'(c), 3'(7 - c)}, pr * (1 << c), pr * (1 << (7 - c)), t);
      end
    end

    // fine divisors: prescaler 3, tx code 2, rx code 4
    reqTag = "R6 R7";
    writeAndMeasure({2'd1, 3'd2, 3'd4}, 12, 48, "R2 base for fine tests");
    txFine = 8'd5;
    repeat (3) @(negedge clk);
    measureGap(0, g);
    checkVal("R6 tx fine 5 with prescaler 3", g, 15);
    measureGap(1, g);
    checkVal("R7 rx keeps coarse while tx fine set", g, 48);
    rxFine = 8'd200;
    measureGap(1, g);
    checkVal("R7 rx fine 200 with prescaler 3", g, 600);
    measureGap(0, g);
    checkVal("R7 tx unaffected by rx fine", g, 15);
    txFine = 8'd0;
    measureGap(0, g);
    checkVal("R6 tx back to coarse code", g, 12);
    rxFine = 8'd0;
    measureGap(1, g);
    checkVal("R7 rx back to coarse code", g, 48);

    // bit enable with non-unit factors
    reqTag = "R9 R11";
    writeAndMeasure({2'd1, 3'd0, 3'd1}, 3, 6, "R9 setup");
    measureGap(3, g);
    checkVal("R9 rx bit enable at 16 x 6", g, 96);
    measureGap(2, g);
    checkVal("R9 tx bit enable at 16 x 3", g, 48);

    // mid-period rewrite: per-cycle model checks the restart
    reqTag = "R10";
    repeat (7) @(negedge clk);
    writeAndMeasure({2'd2, 3'd1, 3'd3}, 8, 32, "R10 rewrite mid period");

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule